// File: doc/BRIEF.md
# Privileged Mask Register Access Gate

This block holds a 128-bit software mask register and decides, for every access request, whether the access may go ahead. A request carries a read/write flag, a width flag (64-bit or 128-bit), the requester's privilege level (0 to 3) and a set of configuration inputs. These inputs come from the monitor level (level 3) and the hypervisor level (level 2), plus feature-present flags. The gate returns one of four outcomes in the same cycle: granted, undefined, trap to level 2 or trap to level 3. A trap outcome also carries a syndrome class code. Only a granted write changes the stored mask, at the clock edge that ends the request cycle.

Stored bits are filtered on their way in and on their way out. Reserved bit positions always read as zero. The overlay-permission field and the encryption-context bit read as zero while their feature flags are low. A 64-bit access touches only the lower half of the register. The denial checks run in a priority order that depends on the privilege level and grows for 128-bit accesses. Elaboration parameters say whether 128-bit support, the monitor level and fine-grained hypervisor trapping exist. Without 128-bit support, every wide request is undefined and everything above bit 63 is reserved.

Top module: `pmask_gate`

## Requirements
- R1: After reset the stored mask is all zeros, so a granted 128-bit read returns zero.
- R2: A granted 64-bit read returns the effective bits [63:0] with rd_data[127:64] zero. A granted 128-bit read returns all 128 effective bits.
- R3: A granted 64-bit write loads bits [63:0] and leaves bits [127:64] unchanged. A granted 128-bit write loads all bits.
- R4: Bits 0, 18 to 49, 64 to 90, 101 to 107, 114, 119, 120, 125 and 126 always store and read as zero.
- R5: Bits 121 to 124 are forced to zero while feat_overlay is low, and bit 108 while feat_encrypt is low. This applies both on write and on read.
- R6: Outcome encoding: 2'b00 granted, 2'b01 undefined, 2'b10 trap to level 2, 2'b11 trap to level 3. Any request with feat_base low is undefined. Any request from level 0 is undefined. Any other request from level 3 is granted.
- R7: At level 1 the checks run in this order, and the first match decides. (a) mon_undef_prio=1 with mon_mask_en=0 gives undefined. (b) With hyp_enabled=1, mon_fgt_en=0 or a zero hypervisor allow bit gives a level-2 trap. (c) mon_mask_en=0 gives undefined if mon_undef_not_trap=1, and a level-3 trap otherwise. If none match, the request is granted.
- R8: Reads consult only hyp_rd_allow and writes consult only hyp_wr_allow.
- R9: At level 2 the hypervisor checks (both the fine-grained check and the wide-access check) are skipped. Only the monitor-enable checks apply, with the same priority-undefined and undefine-instead-of-trap handling.
- R10: A 128-bit request adds checks after the matching monitor-enable checks. A mon_wide_en=0 undefined check follows the priority check. A mon_wide_en=0 check (undefined or level-3 trap) follows the late check. At level 1 only, a level-2 trap applies after the fine-grained check when hyp_enabled=1 and either hyp_xctl_en=0 or hyp_wide_en=0.
- R11: A trap from a 64-bit request reports syndrome 0x18 and a trap from a 128-bit request reports 0x14. syndrome is zero for any outcome that is not a trap.
- R12: The mask changes only on a granted write. rd_data is zero for writes, idle cycles and any request that is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 for 128-bit access, 0 for 64-bit |
| req_el | input | 2 | Privilege level of the requester |
| req_wdata | input | 128 | Write data (upper half used by wide writes only) |
| feat_base | input | 1 | Base feature present |
| feat_overlay | input | 1 | Permission-overlay feature present |
| feat_encrypt | input | 1 | Memory-encryption feature present |
| mon_mask_en | input | 1 | Monitor enable for this register |
| mon_fgt_en | input | 1 | Monitor enable for fine-grained hypervisor traps |
| mon_wide_en | input | 1 | Monitor enable for 128-bit accesses |
| mon_undef_prio | input | 1 | Monitor denial is reported as undefined ahead of all other checks |
| mon_undef_not_trap | input | 1 | Monitor denial gives undefined instead of a level-3 trap |
| hyp_enabled | input | 1 | Hypervisor level enabled |
| hyp_rd_allow | input | 1 | Hypervisor per-register read allow (0 traps) |
| hyp_wr_allow | input | 1 | Hypervisor per-register write allow (0 traps) |
| hyp_xctl_en | input | 1 | Hypervisor extended control register enabled |
| hyp_wide_en | input | 1 | Hypervisor enable for 128-bit accesses |
| rsp_outcome | output | 2 | Outcome code |
| rsp_syndrome | output | 6 | Syndrome class for trap outcomes |
| rd_data | output | 128 | Read data |

## Verification
The embedded assertions check several properties on every clock. Level 0 is always undefined. Level 3 with the base feature present is always granted. Level 2 never traps to level 2. The syndrome is zero outside traps. Reserved positions never hold a one, and denied requests return zero data. A narrow write never moves the upper half, and the mask holds whenever no write is granted. The full priority ordering at level 1, the read/write allow-bit split, the wide-access additions and the feature-flag filtering of readback only show up in the bench. There, a behavioural model runs alongside the design through directed corner cases and a random sweep of configurations.

// File: rtl/pmask_pkg.sv
package pmask_pkg;

   typedef enum logic [1:0] {
      OUT_GRANT    = 2'b00,
      OUT_UNDEF    = 2'b01,
      OUT_TRAP_HYP = 2'b10,
      OUT_TRAP_MON = 2'b11
   } outcome_e;

   typedef struct packed {
      logic feat_base;
      logic mon_mask_en;
      logic mon_fgt_en;
      logic mon_wide_en;
      logic mon_undef_prio;
      logic mon_undef_not_trap;
      logic hyp_enabled;
      logic hyp_rd_allow;
      logic hyp_wr_allow;
      logic hyp_xctl_en;
      logic hyp_wide_en;
   } gate_cfg_t;

   localparam int OVL_LO  = 121;
   localparam int OVL_HI  = 124;
   localparam int ENC_BIT = 108;

   // Reserved-zero positions; the wide map applies when 128-bit support exists
   function automatic bit resv_bit(input int b, input bit wide);
      if (!wide)
         return (b == 0) || (b >= 18 && b <= 49) || (b >= 64);
      return (b == 0) || (b >= 18 && b <= 49) || (b >= 64 && b <= 90) ||
             (b >= 101 && b <= 107) || (b == 114) || (b == 119) || (b == 120) ||
             (b == 125) || (b == 126);
   endfunction

endpackage

// File: rtl/pmask_keep.sv
module pmask_keep
   import pmask_pkg::*;
#(
   parameter int MASK_W  = 128,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic              feat_overlay,
   input  logic              feat_encrypt,
   output logic [MASK_W-1:0] keep_live,
   output logic [MASK_W-1:0] keep_fixed
);

   for (genvar gi = 0; gi < MASK_W; gi++) begin : g_bit
      localparam bit RESV = resv_bit(gi, WIDE_EN);
      assign keep_fixed[gi] = !RESV;
      if (RESV) begin : g_resv
         assign keep_live[gi] = 1'b0;
      end else if (gi >= OVL_LO && gi <= OVL_HI) begin : g_ovl
         assign keep_live[gi] = feat_overlay;
      end else if (gi == ENC_BIT) begin : g_enc
         assign keep_live[gi] = feat_encrypt;
      end else begin : g_plain
         assign keep_live[gi] = 1'b1;
      end
   end

endmodule

// File: rtl/pmask_perm.sv
module pmask_perm
   import pmask_pkg::*;
#(
   parameter bit HAS_MON  = 1'b1,
   parameter bit HAS_FGT  = 1'b1,
   parameter bit WIDE_EN  = 1'b1,
   parameter int SYN_W    = 6,
   parameter logic [SYN_W-1:0] SYN_NARROW = 'h18,
   parameter logic [SYN_W-1:0] SYN_WIDE   = 'h14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             req_wide,
   input  logic [1:0]       req_el,
   input  gate_cfg_t        cfg,
   output outcome_e         outcome,
   output logic [SYN_W-1:0] syndrome
);

   localparam int N_ST = 6;

   logic [N_ST-1:0] stage_hit;
   outcome_e        stage_res [N_ST];
   outcome_e        staged;
   outcome_e        late_res;
   logic            mon_block;
   logic            wide_block;
   logic            sel_allow;
   logic            on_el1;
   logic            is_trap;

   always_comb begin
      sel_allow  = req_write ? cfg.hyp_wr_allow : cfg.hyp_rd_allow;
      mon_block  = HAS_MON && !cfg.mon_mask_en;
      wide_block = HAS_MON && req_wide && !cfg.mon_wide_en;
      on_el1     = (req_el == 2'd1);
      late_res   = cfg.mon_undef_not_trap ? OUT_UNDEF : OUT_TRAP_MON;

      // ordered stages, lowest index wins
      stage_hit[0] = cfg.mon_undef_prio && mon_block;
      stage_res[0] = OUT_UNDEF;
      stage_hit[1] = cfg.mon_undef_prio && wide_block;
      stage_res[1] = OUT_UNDEF;
      stage_hit[2] = on_el1 && HAS_FGT && cfg.hyp_enabled &&
                     ((HAS_MON && !cfg.mon_fgt_en) || !sel_allow);
      stage_res[2] = OUT_TRAP_HYP;
      stage_hit[3] = on_el1 && req_wide && cfg.hyp_enabled &&
                     (!cfg.hyp_xctl_en || !cfg.hyp_wide_en);
      stage_res[3] = OUT_TRAP_HYP;
      stage_hit[4] = mon_block;
      stage_res[4] = late_res;
      stage_hit[5] = wide_block;
      stage_res[5] = late_res;

      staged = OUT_GRANT;
      for (int k = N_ST - 1; k >= 0; k--) begin
         if (stage_hit[k]) staged = stage_res[k];
      end

      if (!req_valid)                 outcome = OUT_GRANT;
      else if (!cfg.feat_base)        outcome = OUT_UNDEF;
      else if (req_wide && !WIDE_EN)  outcome = OUT_UNDEF;
      else begin
         case (req_el)
            2'd0:    outcome = OUT_UNDEF;
            2'd3:    outcome = OUT_GRANT;
            default: outcome = staged;
         endcase
      end

      is_trap  = req_valid && (outcome == OUT_TRAP_HYP || outcome == OUT_TRAP_MON);
      syndrome = is_trap ? (req_wide ? SYN_WIDE : SYN_NARROW) : '0;
   end

   // R6: level 0 never gets through
   a_r6_el0_undef: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_el == 2'd0) |-> outcome == OUT_UNDEF);

   // R6: monitor level always passes when the feature exists
   a_r6_el3_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cfg.feat_base && req_el == 2'd3 && (!req_wide || WIDE_EN))
      |-> outcome == OUT_GRANT);

   // R9: hypervisor checks never apply to level 2 itself
   a_r9_el2_no_hyp_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_el == 2'd2) |-> outcome != OUT_TRAP_HYP);

   // R11: syndrome only accompanies traps
   a_r11_syn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (outcome == OUT_GRANT || outcome == OUT_UNDEF) |-> syndrome == '0);

endmodule

// File: rtl/pmask_store.sv
module pmask_store #(
   parameter int MASK_W = 128,
   parameter int HALF_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [MASK_W-1:0] wdata,
   output logic [MASK_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         if (wr_lo) q[HALF_W-1:0]      <= wdata[HALF_W-1:0];
         if (wr_hi) q[MASK_W-1:HALF_W] <= wdata[MASK_W-1:HALF_W];
      end
   end

   // R3: a narrow write leaves the upper half alone
   a_r3_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> q[MASK_W-1:HALF_W] == $past(q[MASK_W-1:HALF_W]));

   // R12: no granted write, no change
   a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_lo && !wr_hi) |=> $stable(q));

endmodule

// File: rtl/pmask_gate.sv
module pmask_gate
   import pmask_pkg::*;
#(
   parameter int MASK_W   = 128,
   parameter int HALF_W   = MASK_W / 2,
   parameter int SYN_W    = 6,
   parameter bit WIDE_EN  = 1'b1,
   parameter bit HAS_MON  = 1'b1,
   parameter bit HAS_FGT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_wide,
   input  logic [1:0]        req_el,
   input  logic [MASK_W-1:0] req_wdata,
   input  logic              feat_base,
   input  logic              feat_overlay,
   input  logic              feat_encrypt,
   input  logic              mon_mask_en,
   input  logic              mon_fgt_en,
   input  logic              mon_wide_en,
   input  logic              mon_undef_prio,
   input  logic              mon_undef_not_trap,
   input  logic              hyp_enabled,
   input  logic              hyp_rd_allow,
   input  logic              hyp_wr_allow,
   input  logic              hyp_xctl_en,
   input  logic              hyp_wide_en,
   output logic [1:0]        rsp_outcome,
   output logic [SYN_W-1:0]  rsp_syndrome,
   output logic [MASK_W-1:0] rd_data
);

   localparam logic [MASK_W-1:0] LO_ONLY = {{(MASK_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

   if (MASK_W != 128) begin : g_bad_width
      $error("pmask_gate: the reserved-bit map assumes a 128-bit register");
   end
   if (HALF_W * 2 != MASK_W) begin : g_bad_half
      $error("pmask_gate: HALF_W must be half of MASK_W");
   end
   if (SYN_W < 5) begin : g_bad_syn
      $error("pmask_gate: SYN_W too narrow for the syndrome classes");
   end

   gate_cfg_t         cfg;
   outcome_e          outcome;
   logic [MASK_W-1:0] keep_live;
   logic [MASK_W-1:0] keep_fixed;
   logic [MASK_W-1:0] mask_q;
   logic              granted;
   logic              wr_lo;
   logic              wr_hi;

   assign cfg = '{feat_base:          feat_base,
                  mon_mask_en:        mon_mask_en,
                  mon_fgt_en:         mon_fgt_en,
                  mon_wide_en:        mon_wide_en,
                  mon_undef_prio:     mon_undef_prio,
                  mon_undef_not_trap: mon_undef_not_trap,
                  hyp_enabled:        hyp_enabled,
                  hyp_rd_allow:       hyp_rd_allow,
                  hyp_wr_allow:       hyp_wr_allow,
                  hyp_xctl_en:        hyp_xctl_en,
                  hyp_wide_en:        hyp_wide_en};

   pmask_keep #(.MASK_W(MASK_W), .WIDE_EN(WIDE_EN)) keep_i (
      .feat_overlay (feat_overlay),
      .feat_encrypt (feat_encrypt),
      .keep_live    (keep_live),
      .keep_fixed   (keep_fixed)
   );

   pmask_perm #(
      .HAS_MON (HAS_MON),
      .HAS_FGT (HAS_FGT),
      .WIDE_EN (WIDE_EN),
      .SYN_W   (SYN_W)
   ) perm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_wide  (req_wide),
      .req_el    (req_el),
      .cfg       (cfg),
      .outcome   (outcome),
      .syndrome  (rsp_syndrome)
   );

   assign granted = req_valid && (outcome == OUT_GRANT);
   assign wr_lo   = granted && req_write;
   assign wr_hi   = wr_lo && req_wide;

   pmask_store #(.MASK_W(MASK_W), .HALF_W(HALF_W)) store_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (wr_lo),
      .wr_hi (wr_hi),
      .wdata (req_wdata & keep_live),
      .q     (mask_q)
   );

   always_comb begin
      rd_data = '0;
      if (granted && !req_write) begin
         rd_data = mask_q & keep_live;
         if (!req_wide) rd_data = rd_data & LO_ONLY;
      end
   end

   assign rsp_outcome = outcome;

   // R4: reserved positions never hold a one
   a_r4_resv_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q & ~keep_fixed) == '0);

   // R12: refused requests return no data
   a_r12_rdata_denied: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && rsp_outcome != 2'b00) |-> rd_data == '0);

endmodule

// File: tb/pmask_gate_tb.sv
`timescale 1ns/1ps
module pmask_gate_tb_top;

   localparam real HALF_NS = 2.5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 0, req_write = 0, req_wide = 0;
   logic [1:0]   req_el = 2'd3;
   logic [127:0] req_wdata = '0;
   logic feat_base, feat_overlay, feat_encrypt;
   logic mon_mask_en, mon_fgt_en, mon_wide_en, mon_undef_prio, mon_undef_not_trap;
   logic hyp_enabled, hyp_rd_allow, hyp_wr_allow, hyp_xctl_en, hyp_wide_en;
   logic [1:0]   rsp_outcome;
   logic [5:0]   rsp_syndrome;
   logic [127:0] rd_data;

   int n_chk = 0;
   int n_fail = 0;
   logic [127:0] model = '0;
   logic [127:0] resv_keep;

   always #(HALF_NS) clk = ~clk;

   pmask_gate dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_wide(req_wide), .req_el(req_el), .req_wdata(req_wdata),
      .feat_base(feat_base), .feat_overlay(feat_overlay), .feat_encrypt(feat_encrypt),
      .mon_mask_en(mon_mask_en), .mon_fgt_en(mon_fgt_en), .mon_wide_en(mon_wide_en),
      .mon_undef_prio(mon_undef_prio), .mon_undef_not_trap(mon_undef_not_trap),
      .hyp_enabled(hyp_enabled), .hyp_rd_allow(hyp_rd_allow), .hyp_wr_allow(hyp_wr_allow),
      .hyp_xctl_en(hyp_xctl_en), .hyp_wide_en(hyp_wide_en),
      .rsp_outcome(rsp_outcome), .rsp_syndrome(rsp_syndrome), .rd_data(rd_data)
   );

   task automatic clr(input int hi, input int lo);
      for (int b = lo; b <= hi; b++) resv_keep[b] = 1'b0;
   endtask

   function automatic logic [127:0] keep_now();
      logic [127:0] k = resv_keep;
      if (!feat_overlay) k[124:121] = 4'h0;
      if (!feat_encrypt) k[108] = 1'b0;
      return k;
   endfunction

   // behavioural reference: early-return decision list
   function automatic logic [1:0] ref_gate();
      logic allow;
      if (!req_valid) return 2'b00;
      if (!feat_base || req_el == 2'd0) return 2'b01;
      if (req_el == 2'd3) return 2'b00;
      if (mon_undef_prio && !mon_mask_en) return 2'b01;
      if (mon_undef_prio && req_wide && !mon_wide_en) return 2'b01;
      if (req_el == 2'd1 && hyp_enabled) begin
         allow = req_write ? hyp_wr_allow : hyp_rd_allow;
         if (!mon_fgt_en || !allow) return 2'b10;
         if (req_wide && !(hyp_xctl_en && hyp_wide_en)) return 2'b10;
      end
      if (!mon_mask_en || (req_wide && !mon_wide_en))
         return mon_undef_not_trap ? 2'b01 : 2'b11;
      return 2'b00;
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic open_cfg();
      feat_base = 1; feat_overlay = 1; feat_encrypt = 1;
      mon_mask_en = 1; mon_fgt_en = 1; mon_wide_en = 1;
      mon_undef_prio = 0; mon_undef_not_trap = 0;
      hyp_enabled = 1; hyp_rd_allow = 1; hyp_wr_allow = 1;
      hyp_xctl_en = 1; hyp_wide_en = 1;
   endtask

   task automatic req(input logic wr, input logic wide, input logic [1:0] el,
                      input logic [127:0] d);
      req_valid = 1; req_write = wr; req_wide = wide; req_el = el; req_wdata = d;
   endtask

   // compare against the model mid-cycle, then advance one clock
   task automatic apply(input string tag, input int lit);
      logic [1:0]   eo;
      logic [5:0]   es;
      logic [127:0] er;
      logic [127:0] kp;
      #1;
      kp = keep_now();
      eo = ref_gate();
      es = (req_valid && eo[1]) ? (req_wide ? 6'h14 : 6'h18) : 6'h00;
      er = '0;
      if (req_valid && eo == 2'b00 && !req_write) begin
         er = model & kp;
         if (!req_wide) er[127:64] = '0;
      end
      if (lit >= 0) chk(tag, "outcome-literal", {126'd0, rsp_outcome}, lit);
      chk(tag, "outcome", {126'd0, rsp_outcome}, {126'd0, eo});
      chk(tag, "syndrome", {122'd0, rsp_syndrome}, {122'd0, es});
      chk(tag, "rd_data", rd_data, er);
      if (req_valid && eo == 2'b00 && req_write) begin
         model[63:0] = req_wdata[63:0] & kp[63:0];
         if (req_wide) model[127:64] = req_wdata[127:64] & kp[127:64];
      end
      @(negedge clk);
   endtask

   initial begin
      #(HALF_NS * 2.0 * 150000.0);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      resv_keep = '1;
      clr(0, 0); clr(49, 18); clr(90, 64); clr(107, 101);
      clr(114, 114); clr(120, 119); clr(126, 125);
      open_cfg();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;

      // R1: cleared after reset
      req(0, 1, 3, '0);              apply("R1", 0);
      chk("R1", "reset-read", rd_data, '0);
      // R4: all-ones write keeps only legal bits
      req(1, 1, 3, '1);              apply("R4", 0);
      req(0, 1, 3, '0);              apply("R4", 0);
      // R2: narrow read
      req(0, 0, 3, '0);              apply("R2", 0);
      // R3: narrow write then wide read
      req(1, 0, 3, {64'h0, 64'h0123_4567_89AB_CDEF}); apply("R3", 0);
      req(0, 1, 3, '0);              apply("R3", 0);
      req(1, 1, 3, {64'hFFFF_0000_FFFF_0000, 64'h0});  apply("R3", 0);
      req(0, 1, 3, '0);              apply("R3", 0);
      // R5: feature-gated bits
      req(1, 1, 3, '1);              apply("R5", 0);
      feat_overlay = 0; feat_encrypt = 0;
      req(0, 1, 3, '0);              apply("R5", 0);
      req(1, 1, 3, '1);              apply("R5", 0);
      feat_overlay = 1; feat_encrypt = 1;
      req(0, 1, 3, '0);              apply("R5", 0);
      // R6: base absent, level 0, level 3
      req(0, 0, 0, '0);              apply("R6", 1);
      feat_base = 0; req(0, 1, 3, '0); apply("R6", 1);
      open_cfg(); mon_mask_en = 0; hyp_rd_allow = 0; req(0, 0, 3, '0); apply("R6", 0);
      // R7: level-1 narrow ordering
      open_cfg(); mon_undef_prio = 1; mon_mask_en = 0; hyp_rd_allow = 0;
      req(0, 0, 1, '0);              apply("R7", 1);
      open_cfg(); mon_mask_en = 0;   req(0, 0, 1, '0); apply("R7", 3);
      mon_undef_not_trap = 1;        req(0, 0, 1, '0); apply("R7", 1);
      open_cfg(); mon_mask_en = 0; hyp_rd_allow = 0; req(0, 0, 1, '0); apply("R7", 2);
      open_cfg(); mon_fgt_en = 0;    req(0, 0, 1, '0); apply("R7", 2);
      open_cfg(); hyp_enabled = 0; mon_fgt_en = 0; hyp_rd_allow = 0; req(0, 0, 1, '0); apply("R7", 0);
      open_cfg();                    req(0, 0, 1, '0); apply("R7", 0);
      // R8: read/write allow bits are separate
      open_cfg(); hyp_rd_allow = 0;  req(1, 0, 1, 128'h5A5A_0000_0000_0000_F0F0_0000_0000_0F00); apply("R8", 0);
      req(0, 0, 1, '0);              apply("R8", 2);
      open_cfg(); hyp_wr_allow = 0;  req(1, 0, 1, '1); apply("R8", 2);
      req(0, 0, 1, '0);              apply("R8", 0);
      // R9: level 2 skips hypervisor checks
      open_cfg(); hyp_rd_allow = 0; mon_fgt_en = 0; req(0, 0, 2, '0); apply("R9", 0);
      hyp_xctl_en = 0; req(0, 1, 2, '0); apply("R9", 0);
      mon_mask_en = 0;               req(0, 0, 2, '0); apply("R9", 3);
      mon_undef_prio = 1;            req(0, 0, 2, '0); apply("R9", 1);
      // R10: wide additions
      open_cfg(); hyp_xctl_en = 0;   req(0, 1, 1, '0); apply("R10", 2);
      open_cfg(); hyp_wide_en = 0;   req(0, 1, 1, '0); apply("R10", 2);
      open_cfg(); mon_wide_en = 0;   req(0, 1, 1, '0); apply("R10", 3);
      mon_undef_prio = 1;            req(0, 1, 1, '0); apply("R10", 1);
      open_cfg(); mon_wide_en = 0; mon_undef_not_trap = 1; req(0, 1, 2, '0); apply("R10", 1);
      open_cfg(); mon_wide_en = 0;   req(0, 0, 1, '0); apply("R10", 0);
      // R11: syndrome classes
      open_cfg(); hyp_rd_allow = 0; hyp_xctl_en = 0; req(0, 1, 1, '0); apply("R11", 2);
      chk("R11", "wide-syndrome", {122'd0, rsp_syndrome}, 128'h14);
      open_cfg(); mon_mask_en = 0;   req(0, 0, 1, '0); apply("R11", 3);
      // R12: refused write leaves mask, idle gives no data
      open_cfg(); hyp_wr_allow = 0;  req(1, 1, 1, '0); apply("R12", 2);
      req(0, 1, 3, '0);              apply("R12", 0);
      req_valid = 0;                 apply("R12", 0);

      // random sweep, every cycle against the model
      for (int i = 0; i < 600; i++) begin
         logic [15:0] r;
         r = 16'($urandom);
         feat_base = (r[1:0] != 0); feat_overlay = r[2]; feat_encrypt = r[3];
         mon_mask_en = r[4] | r[5]; mon_fgt_en = r[6] | r[7]; mon_wide_en = r[8] | r[5];
         mon_undef_prio = r[9]; mon_undef_not_trap = r[10]; hyp_enabled = r[11];
         hyp_rd_allow = r[12] | r[13]; hyp_wr_allow = r[14] | r[13]; hyp_xctl_en = r[15] | r[4];
         hyp_wide_en = r[0] | r[6];
         req(1'($urandom), 1'($urandom), 2'($urandom),
             {$urandom, $urandom, $urandom, $urandom});
         req_valid = ($urandom % 8) != 0;
         apply("R7", -1);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule